// File: doc/BRIEF.md
# Interleaved Multithread Issue Sequencer

This block is the thread-selection front end of a processor that switches hardware threads on every clock. Each of `NTHR` threads owns a private program counter and an enable flag. Every cycle the sequencer picks one thread slot, presents that thread's PC as a fetch request, and pushes a thread tag down a tag pipeline. When the tag reaches the last stage, the instruction retires. The execution stub outside the block then tells the sequencer whether the instruction branched. The sequencer updates only the PC of the tagged thread.

In the default rotation mode, slots follow a fixed circular order that starts at thread 0 after reset. A disabled thread's slot issues a bubble and is not given to another thread. Every enabled thread therefore issues with exact, unchanging spacing, whatever the other threads do. A build parameter selects a skip mode instead. In that mode the sequencer moves to the next enabled thread that has nothing in flight, trading fixed timing for denser issue. Supported pipeline depths run from 2 to `NTHR-1`. In that range a thread's previous instruction has always written back before its next one is read, so the block needs no stall or bypass logic in rotation mode.

Top module: `barrel_seq`

## Requirements
- R1: While `rst` is high, `issue_vld` and `retire_vld` are 0. After reset only thread 0 is enabled and thread t's PC is `START_BASE + t*START_STRIDE`. The first cycle after reset is released shows thread 0 issuing at `START_BASE`.
- R2: In rotation mode, the slot thread number advances by one each cycle, wrapping from `NTHR-1` to 0. `issue_vld` is 1 only when the slot's thread is enabled. A disabled slot is a bubble.
- R3: In rotation mode, successive issues of any one thread are a whole multiple of `NTHR` cycles apart, and exactly `NTHR` apart while it stays enabled.
- R4: Two valid issues in adjacent cycles never carry the same thread number.
- R5: `issue_pc` is the issuing thread's own PC. At retirement that thread's PC becomes `wb_target` when `wb_taken` is 1, and otherwise its old value plus 1. No other thread's PC changes.
- R6: An instruction visible on the issue port in cycle c appears on the retire port in cycle c+`NSTG`-1 with the same thread number and PC. `wb_taken`/`wb_target` are sampled at the end of that cycle.
- R7: With `ctl_vld` high, the thread flag selected by `ctl_tid` is set to `ctl_on` at the clock edge. A slot captured at that same edge still uses the old flag, so a thread enabled just as its slot comes round first issues one full rotation later.
- R8: Disabling a thread that has an instruction in flight does not cancel that instruction. It still retires with its own thread number.
- R9: In skip mode, the sequencer searches circularly from the thread after the last one it issued. It issues the first thread that is enabled and has nothing in flight, or a bubble if no thread qualifies.
- R10: A thread never issues while an earlier instruction of its own has not yet retired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_vld | input | 1 | Enable/disable command strobe |
| ctl_tid | input | TW | Thread addressed by the command |
| ctl_on | input | 1 | 1 enables the thread, 0 disables it |
| wb_taken | input | 1 | Retiring instruction redirects its thread |
| wb_target | input | PCW | Redirect address for the retiring thread |
| issue_vld | output | 1 | A fetch request is issued this cycle |
| issue_tid | output | TW | Thread of the fetch request |
| issue_pc | output | PCW | Fetch address (the thread's PC) |
| retire_vld | output | 1 | An instruction retires this cycle |
| retire_tid | output | TW | Thread tag of the retiring instruction |
| retire_pc | output | PCW | PC of the retiring instruction |

## Verification
The assertions assume that `ctl_tid` names an existing thread and that `wb_taken` and `wb_target` matter only in a cycle where `retire_vld` is high. They also assume `NSTG` lies between 2 and `NTHR-1`; the tag-ownership checks rely on that range. The stimulus draws thread numbers modulo the thread count and uses the default depth of 4 with 8 threads. Redirects are driven at random in every cycle, so the bench also confirms that values offered outside a retirement are ignored.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic {
        ROT_FIXED = 1'b0,
        ROT_SKIP  = 1'b1
    } rot_mode_e;

    // circular successor of a thread index
    function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

    // start address for thread t
    function automatic logic [31:0] start_addr(int unsigned base, int unsigned stride,
                                               int unsigned t);
        return 32'(base + stride * t);
    endfunction

endpackage

// File: rtl/bseq_slot_pick.sv
module bseq_slot_pick
    import bseq_pkg::*;
#(
    parameter int        NTHR = 8,
    parameter int        TW   = 3,
    parameter rot_mode_e MODE = ROT_FIXED
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NTHR-1:0] active,
    input  logic [NTHR-1:0] busy,
    output logic            pick_vld,
    output logic [TW-1:0]   pick_tid
);

    generate
        if (MODE == ROT_FIXED) begin : g_fixed
            logic [TW-1:0] slot_q;

            always_ff @(posedge clk) begin
                if (rst)
                    slot_q <= '0;
                else if (slot_q == TW'(NTHR - 1))
                    slot_q <= '0;
                else
                    slot_q <= slot_q + 1'b1;
            end

            assign pick_vld = active[slot_q] && !busy[slot_q];
            assign pick_tid = slot_q;
        end else begin : g_skip
            logic [TW-1:0] last_q;
            logic          found;
            logic [TW-1:0] cand;

            always_comb begin
                int unsigned   c;
                logic [TW-1:0] ci;
                found = 1'b0;
                cand  = '0;
                c     = 32'(last_q);
                for (int k = 0; k < NTHR; k++) begin
                    c  = ring_next(c, NTHR);
                    ci = TW'(c);
                    if (!found && active[ci] && !busy[ci]) begin
                        found = 1'b1;
                        cand  = ci;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst)
                    last_q <= TW'(NTHR - 1);
                else if (found)
                    last_q <= cand;
            end

            assign pick_vld = found;
            assign pick_tid = cand;
        end
    endgenerate

endmodule

// File: rtl/bseq_pc_file.sv
module bseq_pc_file
    import bseq_pkg::*;
#(
    parameter int          NTHR         = 8,
    parameter int          TW           = 3,
    parameter int          PCW          = 16,
    parameter int unsigned START_BASE   = 32'h100,
    parameter int unsigned START_STRIDE = 32'h100
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [TW-1:0]  rd_tid,
    output logic [PCW-1:0] rd_pc,
    input  logic           wb_vld,
    input  logic [TW-1:0]  wb_tid,
    input  logic           wb_taken,
    input  logic [PCW-1:0] wb_target
);

    logic [PCW-1:0] pc_q [NTHR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NTHR; t++)
                pc_q[t] <= PCW'(start_addr(START_BASE, START_STRIDE, t));
        end else if (wb_vld) begin
            pc_q[wb_tid] <= wb_taken ? wb_target : pc_q[wb_tid] + 1'b1;
        end
    end

    assign rd_pc = pc_q[rd_tid];

endmodule

// File: rtl/bseq_tag_pipe.sv
module bseq_tag_pipe #(
    parameter int NSTG = 4,
    parameter int TW   = 3,
    parameter int PCW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_vld,
    input  logic [TW-1:0]  in_tid,
    input  logic [PCW-1:0] in_pc,
    output logic           head_vld,
    output logic [TW-1:0]  head_tid,
    output logic [PCW-1:0] head_pc,
    output logic           tail_vld,
    output logic [TW-1:0]  tail_tid,
    output logic [PCW-1:0] tail_pc
);

    typedef struct packed {
        logic           vld;
        logic [TW-1:0]  tid;
        logic [PCW-1:0] pc;
    } stage_t;

    stage_t stg_q [NSTG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSTG; s++)
                stg_q[s] <= '0;
        end else begin
            stg_q[0] <= {in_vld, in_tid, in_pc};
            for (int s = 1; s < NSTG; s++)
                stg_q[s] <= stg_q[s-1];
        end
    end

    assign head_vld = stg_q[0].vld;
    assign head_tid = stg_q[0].tid;
    assign head_pc  = stg_q[0].pc;
    assign tail_vld = stg_q[NSTG-1].vld;
    assign tail_tid = stg_q[NSTG-1].tid;
    assign tail_pc  = stg_q[NSTG-1].pc;

endmodule

// File: rtl/barrel_seq.sv
module barrel_seq
    import bseq_pkg::*;
#(
    parameter int          NTHR         = 8,
    parameter int          NSTG         = 4,
    parameter int          PCW          = 16,
    parameter int unsigned START_BASE   = 32'h100,
    parameter int unsigned START_STRIDE = 32'h100,
    parameter rot_mode_e   MODE         = ROT_FIXED,
    localparam int         TW           = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ctl_vld,
    input  logic [TW-1:0]  ctl_tid,
    input  logic           ctl_on,
    input  logic           wb_taken,
    input  logic [PCW-1:0] wb_target,
    output logic           issue_vld,
    output logic [TW-1:0]  issue_tid,
    output logic [PCW-1:0] issue_pc,
    output logic           retire_vld,
    output logic [TW-1:0]  retire_tid,
    output logic [PCW-1:0] retire_pc
);

    logic [NTHR-1:0] active_q;
    logic [NTHR-1:0] busy_q;
    logic            pick_vld;
    logic [TW-1:0]   pick_tid;
    logic [PCW-1:0]  pick_pc;

    // thread enable flags: thread 0 alone after reset
    always_ff @(posedge clk) begin
        if (rst)
            active_q <= NTHR'(1);
        else if (ctl_vld)
            active_q[ctl_tid] <= ctl_on;
    end

    // in-flight flag per thread: set on issue, cleared on retirement
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
        end else begin
            if (retire_vld)
                busy_q[retire_tid] <= 1'b0;
            if (pick_vld)
                busy_q[pick_tid] <= 1'b1;
        end
    end

    bseq_slot_pick #(
        .NTHR (NTHR),
        .TW   (TW),
        .MODE (MODE)
    ) pick_i (
        .clk      (clk),
        .rst      (rst),
        .active   (active_q),
        .busy     (busy_q),
        .pick_vld (pick_vld),
        .pick_tid (pick_tid)
    );

    bseq_pc_file #(
        .NTHR         (NTHR),
        .TW           (TW),
        .PCW          (PCW),
        .START_BASE   (START_BASE),
        .START_STRIDE (START_STRIDE)
    ) pcs_i (
        .clk       (clk),
        .rst       (rst),
        .rd_tid    (pick_tid),
        .rd_pc     (pick_pc),
        .wb_vld    (retire_vld),
        .wb_tid    (retire_tid),
        .wb_taken  (wb_taken),
        .wb_target (wb_target)
    );

    bseq_tag_pipe #(
        .NSTG (NSTG),
        .TW   (TW),
        .PCW  (PCW)
    ) pipe_i (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (pick_vld),
        .in_tid   (pick_tid),
        .in_pc    (pick_pc),
        .head_vld (issue_vld),
        .head_tid (issue_tid),
        .head_pc  (issue_pc),
        .tail_vld (retire_vld),
        .tail_tid (retire_tid),
        .tail_pc  (retire_pc)
    );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk
    import bseq_pkg::*;
#(
    parameter int        NTHR = 8,
    parameter int        TW   = 3,
    parameter rot_mode_e MODE = ROT_FIXED
) (
    input logic          clk,
    input logic          rst,
    input logic          issue_vld,
    input logic [TW-1:0] issue_tid,
    input logic          retire_vld,
    input logic [TW-1:0] retire_tid
);

    // outstanding instructions as seen on the ports
    logic [NTHR-1:0] outst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outst_q <= '0;
        end else begin
            if (retire_vld)
                outst_q[retire_tid] <= 1'b0;
            if (issue_vld)
                outst_q[issue_tid] <= 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!issue_vld && !retire_vld));

    // R4
    no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        issue_vld |=> (!issue_vld || issue_tid != $past(issue_tid)));

    // R10
    no_hazard_chk: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> !outst_q[issue_tid]);

    // R6
    retire_owned_chk: assert property (@(posedge clk) disable iff (rst)
        retire_vld |-> outst_q[retire_tid]);

    generate
        if (MODE == ROT_FIXED) begin : g_rot
            // R2
            slot_order_chk: assert property (@(posedge clk) disable iff (rst)
                issue_vld |=> (!issue_vld ||
                    issue_tid == (($past(issue_tid) == TW'(NTHR - 1)) ? '0
                                  : $past(issue_tid) + 1'b1)));
        end
    endgenerate

endmodule

bind barrel_seq bseq_chk #(
    .NTHR (NTHR),
    .TW   (TW),
    .MODE (MODE)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .issue_vld  (issue_vld),
    .issue_tid  (issue_tid),
    .retire_vld (retire_vld),
    .retire_tid (retire_tid)
);

// File: tb/barrel_seq_tb_top.sv
`timescale 1ns/1ps
module barrel_seq_tb_top;
    import bseq_pkg::*;

    localparam int NT = 8;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        ctl_vld = 1'b0;
    logic [2:0]  ctl_tid = '0;
    logic        ctl_on  = 1'b0;
    logic        tk [2];
    logic [15:0] tg [2];
    logic        iv [2];
    logic [2:0]  it [2];
    logic [15:0] ip [2];
    logic        rv [2];
    logic [2:0]  rt [2];
    logic [15:0] rp [2];

    barrel_seq #(.NTHR(NT), .NSTG(NS), .MODE(ROT_FIXED)) dut_i (
        .clk(clk), .rst(rst), .ctl_vld(ctl_vld), .ctl_tid(ctl_tid), .ctl_on(ctl_on),
        .wb_taken(tk[0]), .wb_target(tg[0]),
        .issue_vld(iv[0]), .issue_tid(it[0]), .issue_pc(ip[0]),
        .retire_vld(rv[0]), .retire_tid(rt[0]), .retire_pc(rp[0]));

    barrel_seq #(.NTHR(NT), .NSTG(NS), .MODE(ROT_SKIP)) dut_skip (
        .clk(clk), .rst(rst), .ctl_vld(ctl_vld), .ctl_tid(ctl_tid), .ctl_on(ctl_on),
        .wb_taken(tk[1]), .wb_target(tg[1]),
        .issue_vld(iv[1]), .issue_tid(it[1]), .issue_pc(ip[1]),
        .retire_vld(rv[1]), .retire_tid(rt[1]), .retire_pc(rp[1]));

    // reference model state, index 0 = rotation, 1 = skip
    logic [15:0] mpc   [2][NT];
    bit          mact  [2][NT];
    bit          mbusy [2][NT];
    int          mslot;
    int          mptr;
    bit          mv [2][NS];
    int          mt [2][NS];
    logic [15:0] mp [2][NS];

    // port-level bookkeeping
    int  last_iss [2][NT];
    bit  outst    [2][NT];
    bit  prev_v   [2];
    int  prev_t   [2];
    int  cyc;
    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic m_reset();
        for (int m = 0; m < 2; m++) begin
            for (int t = 0; t < NT; t++) begin
                mpc[m][t]      = 16'(16'h100 * (t + 1));
                mact[m][t]     = (t == 0);
                mbusy[m][t]    = 1'b0;
                last_iss[m][t] = -1;
                outst[m][t]    = 1'b0;
            end
            for (int s = 0; s < NS; s++) begin
                mv[m][s] = 1'b0; mt[m][s] = 0; mp[m][s] = '0;
            end
            prev_v[m] = 1'b0;
            prev_t[m] = 0;
        end
        mslot = 0;
        mptr  = NT - 1;
    endtask

    // what one clock edge does, from the requirements
    task automatic m_step(int m, bit cv, int ct, bit con, bit wtk, logic [15:0] wtg);
        bit          r_v = mv[m][NS-1];
        int          r_t = mt[m][NS-1];
        bit          i_v = 1'b0;
        int          i_t = 0;
        int          c;
        logic [15:0] i_pc;
        if (m == 0) begin
            i_t   = mslot;
            i_v   = mact[0][i_t] && !mbusy[0][i_t];
            mslot = (mslot + 1) % NT;
        end else begin
            c = mptr;
            for (int k = 0; k < NT; k++) begin
                c = (c + 1) % NT;
                if (!i_v && mact[1][c] && !mbusy[1][c]) begin
                    i_v = 1'b1;
                    i_t = c;
                end
            end
            if (i_v) mptr = i_t;
        end
        i_pc = mpc[m][i_t];
        if (r_v) begin
            mpc[m][r_t]   = wtk ? wtg : mpc[m][r_t] + 16'd1;
            mbusy[m][r_t] = 1'b0;
        end
        if (i_v) mbusy[m][i_t] = 1'b1;
        for (int s = NS - 1; s > 0; s--) begin
            mv[m][s] = mv[m][s-1]; mt[m][s] = mt[m][s-1]; mp[m][s] = mp[m][s-1];
        end
        mv[m][0] = i_v; mt[m][0] = i_t; mp[m][0] = i_pc;
        if (cv) mact[m][ct] = con;
    endtask

    task automatic observe();
        string rq;
        for (int m = 0; m < 2; m++) begin
            rq = (m == 0) ? "R2" : "R9";
            chk(rq, "issue_vld", int'(iv[m]), int'(mv[m][0]));
            if (mv[m][0]) begin
                chk(rq, "issue_tid", int'(it[m]), mt[m][0]);
                chk("R5", "issue_pc", int'(ip[m]), int'(mp[m][0]));
            end
            chk("R6", "retire_vld", int'(rv[m]), int'(mv[m][NS-1]));
            if (mv[m][NS-1]) begin
                chk("R6", "retire_tid", int'(rt[m]), mt[m][NS-1]);
                chk("R6", "retire_pc", int'(rp[m]), int'(mp[m][NS-1]));
            end
            if (iv[m]) begin
                if (prev_v[m])
                    chk("R4", "adjacent issue differs", int'(it[m] != 3'(prev_t[m])), 1);
                chk("R10", "issue while in flight", int'(outst[m][it[m]]), 0);
                if (m == 0 && last_iss[0][it[m]] >= 0)
                    chk("R3", "issue spacing mod N", (cyc - last_iss[0][it[m]]) % NT, 0);
                last_iss[m][it[m]] = cyc;
                outst[m][it[m]]    = 1'b1;
            end
            if (rv[m]) outst[m][rt[m]] = 1'b0;
            prev_v[m] = iv[m];
            prev_t[m] = int'(it[m]);
        end
    endtask

    task automatic step_pre();
        @(negedge clk);
        cyc++;
        observe();
    endtask

    task automatic step_drive(bit cv, int ct, bit con, bit wtk, logic [15:0] wtg);
        ctl_vld = cv;
        ctl_tid = 3'(ct);
        ctl_on  = con;
        tk[0]   = wtk;
        tg[0]   = wtg;
        tk[1]   = ($urandom % 3) == 0;
        tg[1]   = 16'($urandom);
        m_step(0, cv, ct, con, tk[0], tg[0]);
        m_step(1, cv, ct, con, tk[1], tg[1]);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit hit;
        void'($urandom(32'h5eed_0c1a));
        tk[0] = 1'b0; tk[1] = 1'b0; tg[0] = '0; tg[1] = '0;
        cyc = 0;
        // R1: quiet outputs in reset
        repeat (3) begin
            @(negedge clk);
            for (int m = 0; m < 2; m++) begin
                chk("R1", "issue_vld in reset", int'(iv[m]), 0);
                chk("R1", "retire_vld in reset", int'(rv[m]), 0);
            end
        end
        rst = 1'b0;
        m_reset();
        step_drive(1'b0, 0, 1'b0, 1'b0, '0);

        // R1: first issue is thread 0 at its start address
        step_pre();
        chk("R1", "first issue vld", int'(iv[0]), 1);
        chk("R1", "first issue tid", int'(it[0]), 0);
        chk("R1", "first issue pc", int'(ip[0]), 16'h100);
        step_drive(1'b0, 0, 1'b0, 1'b0, '0);

        // R5: redirect thread 0 at its retirement
        hit = 1'b0;
        while (!hit) begin
            step_pre();
            hit = rv[0] && rt[0] == 3'd0;
            step_drive(1'b0, 0, 1'b0, hit, 16'h0ab0);
        end
        hit = 1'b0;
        while (!hit) begin
            step_pre();
            if (iv[0] && it[0] == 3'd0) begin
                chk("R5", "pc after taken redirect", int'(ip[0]), 16'h0ab0);
                hit = 1'b1;
            end
            step_drive(1'b0, 0, 1'b0, 1'b0, '0);
        end

        // R7: enable thread 1 just as its slot is captured
        hit = 1'b0;
        while (!hit) begin
            step_pre();
            hit = iv[0] && it[0] == 3'd0;
            step_drive(hit, 1, 1'b1, 1'b0, '0);
        end
        step_pre();
        chk("R7", "slot of newly enabled thread still a bubble", int'(iv[0]), 0);
        step_drive(1'b0, 0, 1'b0, 1'b0, '0);
        for (int k = 1; k <= NT; k++) begin
            step_pre();
            if (k == NT) begin
                chk("R7", "enabled thread issues one rotation later", int'(iv[0]), 1);
                chk("R7", "enabled thread tid", int'(it[0]), 1);
            end
            step_drive(1'b0, 0, 1'b0, 1'b0, '0);
        end

        // R8: disable thread 3 while its instruction is in flight
        step_pre();
        step_drive(1'b1, 3, 1'b1, 1'b0, '0);
        hit = 1'b0;
        while (!hit) begin
            step_pre();
            hit = iv[0] && it[0] == 3'd3;
            step_drive(hit, 3, 1'b0, 1'b0, '0);
        end
        for (int k = 1; k <= NS - 1; k++) begin
            step_pre();
            if (k == NS - 1) begin
                chk("R8", "disabled thread still retires", int'(rv[0]), 1);
                chk("R8", "retiring tid", int'(rt[0]), 3);
            end
            step_drive(1'b0, 0, 1'b0, 1'b0, '0);
        end

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            step_pre();
            step_drive(($urandom % 8) == 0, int'($urandom % NT), ($urandom % 3) != 0,
                       ($urandom % 4) == 0, 16'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule